// File: doc/BRIEF.md
# Memory Chip Select Unit

This block turns a bus address into one of eight active-low memory selects and four active-low byte-lane strobes. There are eight regions. Each one has a base word and an option word, which set:

- where the region sits in the address map and how large it is;
- the width of the memory port behind it;
- how many wait states it needs;
- whether the address is set up one clock before the select asserts, and held one clock after it drops. Reads and writes choose this separately.

Region 0 is the boot region. It is live straight out of reset and matches every address. Its port width comes from two strap inputs that are sampled while reset is held.

The highest region can be marked as a dynamic-memory region. When it is, a hit in that region does not assert its select. The block instead gives a one-cycle hand-off pulse to an external SDRAM controller.

An access that matches no enabled region drives no select. It raises a bus-error pulse after a fixed number of clocks. Software programs the regions through a small write/read register port.

Top module: `memcs_unit`

## Requirements
- R1: Out of reset, every select and strobe is high, `ta`, `bus_err` and `sdram_req` are low, regions 1..7 read back as all zero, region 0's base word reads back with base 0 and the enable bit set, and region 0's option word reads 0xFFFFF0F0 (mask all ones, 15 wait states, no setup or hold).
- R2: The two strap inputs are copied into region 0's width field (base word bits 11:10) on every clock while reset is low. Changing the straps after reset has no effect.
- R3: A region hits when bit 0 of its base word (enable) is 1 and address bits 31:12 equal base bits 31:12 in every position where the option word's mask (bits 31:12) is 0.
- R4: When several regions hit, the lowest-numbered one drives its select.
- R5: A normal access holds exactly one select low for W+1 clocks, where W is option bits 7:4. `ta` pulses high in the last of those clocks only.
- R6: Option bit 3 (read) and bit 1 (write) insert one setup clock before the select falls. Option bit 2 (read) and bit 0 (write) insert one hold clock after it rises. `addr_drive` is high across setup, select and hold.
- R7: Width codes are 00 = 32-bit, 01 = 8-bit and 10 = 16-bit. Size codes are 00 = byte, 01 = half, 10 = word. Lane n is `bs_n[n]`, and strobes are low only while the select is low:
  - an 8-bit port uses lane 0;
  - a 16-bit port uses lane addr[0] for a byte and lanes 1:0 otherwise;
  - a 32-bit port uses lane addr[1:0] for a byte, lanes 3:2 or 1:0 by addr[1] for a half, and all four lanes for a word.
- R8: When base bit 9 of region 7 is 1 and region 7 wins, `sdram_req` pulses for one clock, the clock after the request. No select, strobe or `ta` is driven.
- R9: An access that hits no region drives no select. It pulses `bus_err` in the TIMEOUT-th clock after the request edge.
- R10: `reg_addr[3:1]` picks the region and `reg_addr[0]` picks the option word (1) or the base word (0). Reserved bits read as 0: base bits 8:1, base bit 9 outside region 7, and option bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_bw | input | 2 | Boot port width straps |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Region index and word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_req | input | 1 | Start an access (sampled when idle) |
| acc_write | input | 1 | 1 for a write access |
| acc_size | input | 2 | Access size code |
| acc_addr | input | 32 | Access address |
| cs_n | output | 8 | Active-low region selects |
| bs_n | output | 4 | Active-low byte strobes |
| ta | output | 1 | Transfer acknowledge pulse |
| addr_drive | output | 1 | Address phase active (setup, select, hold) |
| sdram_req | output | 1 | Hand-off pulse to the SDRAM controller |
| bus_err | output | 1 | Unmapped-access error pulse |

## Verification
Two situations are hard to reach from the ports:

- **Priority.** Priority only shows when two enabled regions overlap. The stimulus programs a small region inside a larger, lower-numbered one and then addresses the overlap. The larger region must keep the select.
- **Strap width.** The strapped boot width can only be seen through strobe patterns. The bench therefore resets twice with different strap values and makes a boot access after each reset. Between the two, it changes the straps while out of reset and confirms the readback has not moved.

// File: rtl/memcs_pkg.sv
package memcs_pkg;

  localparam int WAIT_W = 4;
  localparam int HI_W   = 20;

  localparam logic [1:0] BW_32 = 2'b00;
  localparam logic [1:0] BW_8  = 2'b01;
  localparam logic [1:0] BW_16 = 2'b10;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ASSERT, ST_HOLD, ST_MISS, ST_SDRAM
  } seq_state_t;

  // masked compare of the upper address bits
  function automatic logic region_match(input logic [HI_W-1:0] a_hi,
                                        input logic [HI_W-1:0] base,
                                        input logic [HI_W-1:0] mask,
                                        input logic            en);
    return en && ((a_hi & ~mask) == (base & ~mask));
  endfunction

  // active-high lane set for one access
  function automatic logic [3:0] lane_mask(input logic [1:0] size,
                                           input logic [1:0] bw,
                                           input logic [1:0] lo);
    logic [3:0] m;
    case (bw)
      BW_8:  m = 4'b0001;
      BW_16: m = (size == SZ_BYTE) ? (lo[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      default: begin
        if (size == SZ_BYTE)      m = 4'b0001 << lo;
        else if (size == SZ_HALF) m = lo[1] ? 4'b1100 : 4'b0011;
        else                      m = 4'b1111;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/memcs_regs.sv
module memcs_regs
  import memcs_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int SDRAM_IDX = NREG - 1,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       strap_bw,
  input  logic                             reg_we,
  input  logic [IDX_W:0]                   reg_addr,
  input  logic [31:0]                      reg_wdata,
  output logic [31:0]                      reg_rdata,
  output logic [NREG-1:0][HI_W-1:0]        base_q,
  output logic [NREG-1:0][HI_W-1:0]        mask_q,
  output logic [NREG-1:0][1:0]             bw_q,
  output logic [NREG-1:0]                  valid_q,
  output logic [NREG-1:0]                  sdram_q,
  output logic [NREG-1:0][WAIT_W-1:0]      waits_q,
  output logic [NREG-1:0]                  rd_setup_q,
  output logic [NREG-1:0]                  rd_hold_q,
  output logic [NREG-1:0]                  wr_setup_q,
  output logic [NREG-1:0]                  wr_hold_q
);

  logic [IDX_W-1:0] sel_idx;
  logic             sel_opt;
  logic             unused_bit8;

  assign sel_idx     = reg_addr[IDX_W:1];
  assign sel_opt     = reg_addr[0];
  assign unused_bit8 = reg_wdata[8];

  for (genvar g = 0; g < NREG; g++) begin : g_region
    localparam bit BOOT = (g == 0);
    logic base_wr, opt_wr;
    assign base_wr = reg_we && !sel_opt && (sel_idx == IDX_W'(g));
    assign opt_wr  = reg_we &&  sel_opt && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]     <= '0;
        mask_q[g]     <= BOOT ? '1 : '0;
        bw_q[g]       <= BOOT ? strap_bw : BW_32;
        valid_q[g]    <= BOOT;
        waits_q[g]    <= BOOT ? '1 : '0;
        rd_setup_q[g] <= 1'b0;
        rd_hold_q[g]  <= 1'b0;
        wr_setup_q[g] <= 1'b0;
        wr_hold_q[g]  <= 1'b0;
      end else begin
        if (base_wr) begin
          base_q[g]  <= reg_wdata[31:12];
          bw_q[g]    <= reg_wdata[11:10];
          valid_q[g] <= reg_wdata[0];
        end
        if (opt_wr) begin
          mask_q[g]     <= reg_wdata[31:12];
          waits_q[g]    <= reg_wdata[7:4];
          rd_setup_q[g] <= reg_wdata[3];
          rd_hold_q[g]  <= reg_wdata[2];
          wr_setup_q[g] <= reg_wdata[1];
          wr_hold_q[g]  <= reg_wdata[0];
        end
      end
    end

    if (g == SDRAM_IDX) begin : g_sd
      always_ff @(posedge clk) begin
        if (!rst_n)       sdram_q[g] <= 1'b0;
        else if (base_wr) sdram_q[g] <= reg_wdata[9];
      end
    end else begin : g_nosd
      assign sdram_q[g] = 1'b0;
    end
  end

  always_comb begin
    if (sel_opt)
      reg_rdata = {mask_q[sel_idx], 4'b0, waits_q[sel_idx], rd_setup_q[sel_idx],
                   rd_hold_q[sel_idx], wr_setup_q[sel_idx], wr_hold_q[sel_idx]};
    else
      reg_rdata = {base_q[sel_idx], bw_q[sel_idx], sdram_q[sel_idx], 8'b0, valid_q[sel_idx]};
  end

  AST_BASE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sel_opt && sel_idx == '0) |=> (valid_q[0] == $past(reg_wdata[0]))); // R10

endmodule

// File: rtl/memcs_decode.sv
module memcs_decode
  import memcs_pkg::*;
#(
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [HI_W-1:0]           addr_hi,
  input  logic [NREG-1:0][HI_W-1:0] base_q,
  input  logic [NREG-1:0][HI_W-1:0] mask_q,
  input  logic [NREG-1:0]           valid_q,
  output logic [NREG-1:0]           hit_vec,
  output logic                      any_hit,
  output logic [IDX_W-1:0]          win_idx
);

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit_vec[g] = region_match(addr_hi, base_q[g], mask_q[g], valid_q[g]);
  end

  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  AST_WINNER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[win_idx]); // R4
  AST_NONE_BELOW_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec & ((NREG'(1) << win_idx) - NREG'(1))) == '0)); // R4

endmodule

// File: rtl/memcs_seq.sv
module memcs_seq
  import memcs_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int SDRAM_IDX = NREG - 1,
  parameter int TIMEOUT   = 16,
  localparam int IDX_W    = $clog2(NREG),
  localparam int TO_W     = $clog2(TIMEOUT + 1),
  localparam int CNT_W    = (TO_W > WAIT_W) ? TO_W : WAIT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_req,
  input  logic                        acc_write,
  input  logic [1:0]                  acc_size,
  input  logic [1:0]                  acc_lo,
  input  logic                        any_hit,
  input  logic [IDX_W-1:0]            win_idx,
  input  logic [NREG-1:0][1:0]        bw_q,
  input  logic [NREG-1:0]             sdram_q,
  input  logic [NREG-1:0][WAIT_W-1:0] waits_q,
  input  logic [NREG-1:0]             rd_setup_q,
  input  logic [NREG-1:0]             rd_hold_q,
  input  logic [NREG-1:0]             wr_setup_q,
  input  logic [NREG-1:0]             wr_hold_q,
  output logic [NREG-1:0]             cs_n,
  output logic [3:0]                  bs_n,
  output logic                        ta,
  output logic                        addr_drive,
  output logic                        sdram_req,
  output logic                        bus_err
);

  seq_state_t       state_q;
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_q;
  logic [3:0]       lanes_q;

  logic start_acc, use_setup, use_hold, to_sdram, in_assert, last_beat;

  assign start_acc = acc_req && (state_q == ST_IDLE);
  assign use_setup = acc_write ? wr_setup_q[win_idx] : rd_setup_q[win_idx];
  assign use_hold  = acc_write ? wr_hold_q[win_idx]  : rd_hold_q[win_idx];
  assign to_sdram  = sdram_q[win_idx] && (win_idx == IDX_W'(SDRAM_IDX));
  assign in_assert = (state_q == ST_ASSERT);
  assign last_beat = in_assert && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
      lanes_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            cur_q   <= win_idx;
            hold_q  <= use_hold;
            lanes_q <= lane_mask(acc_size, bw_q[win_idx], acc_lo);
            if (!any_hit) begin
              state_q <= ST_MISS;
              cnt_q   <= CNT_W'(TIMEOUT - 1);
            end else if (to_sdram) begin
              state_q <= ST_SDRAM;
            end else begin
              cnt_q   <= CNT_W'(waits_q[win_idx]);
              state_q <= use_setup ? ST_SETUP : ST_ASSERT;
            end
          end
        end
        ST_SETUP:  state_q <= ST_ASSERT;
        ST_ASSERT: begin
          if (cnt_q == '0) state_q <= hold_q ? ST_HOLD : ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_MISS: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cs_n       = in_assert ? ~(NREG'(1) << cur_q) : '1;
    bs_n       = in_assert ? ~lanes_q : 4'hF;
    ta         = last_beat;
    addr_drive = (state_q == ST_SETUP) || in_assert || (state_q == ST_HOLD);
    sdram_req  = (state_q == ST_SDRAM);
    bus_err    = (state_q == ST_MISS) && (cnt_q == '0);
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R5
  AST_TA_ENDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> (&cs_n)); // R5
  AST_SETUP_PRECEDES_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> ((&cs_n) && addr_drive) ##1 !(&cs_n)); // R6
  AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(&bs_n) |-> !(&cs_n)); // R7
  AST_SDRAM_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_req |-> ((&cs_n) && !ta) ##1 !sdram_req); // R8
  AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ((&cs_n) && !addr_drive)); // R9

endmodule

// File: rtl/memcs_unit.sv
module memcs_unit
  import memcs_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int SDRAM_IDX = NREG - 1,
  parameter int TIMEOUT   = 16,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_bw,
  input  logic             reg_we,
  input  logic [IDX_W:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             acc_req,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic [31:0]      acc_addr,
  output logic [NREG-1:0]  cs_n,
  output logic [3:0]       bs_n,
  output logic             ta,
  output logic             addr_drive,
  output logic             sdram_req,
  output logic             bus_err
);

  logic [NREG-1:0][HI_W-1:0]   base_q, mask_q;
  logic [NREG-1:0][1:0]        bw_q;
  logic [NREG-1:0]             valid_q, sdram_q;
  logic [NREG-1:0][WAIT_W-1:0] waits_q;
  logic [NREG-1:0]             rd_setup_q, rd_hold_q, wr_setup_q, wr_hold_q;
  logic [NREG-1:0]             hit_vec;
  logic                        any_hit;
  logic [IDX_W-1:0]            win_idx;
  logic                        unused_mid;

  assign unused_mid = ^acc_addr[11:2];

  memcs_regs #(.NREG(NREG), .SDRAM_IDX(SDRAM_IDX)) i_regs (
    .clk(clk), .rst_n(rst_n), .strap_bw(strap_bw),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_q(base_q), .mask_q(mask_q), .bw_q(bw_q), .valid_q(valid_q), .sdram_q(sdram_q),
    .waits_q(waits_q), .rd_setup_q(rd_setup_q), .rd_hold_q(rd_hold_q),
    .wr_setup_q(wr_setup_q), .wr_hold_q(wr_hold_q)
  );

  memcs_decode #(.NREG(NREG)) i_decode (
    .clk(clk), .rst_n(rst_n), .addr_hi(acc_addr[31:12]),
    .base_q(base_q), .mask_q(mask_q), .valid_q(valid_q),
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  memcs_seq #(.NREG(NREG), .SDRAM_IDX(SDRAM_IDX), .TIMEOUT(TIMEOUT)) i_seq (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
    .acc_size(acc_size), .acc_lo(acc_addr[1:0]), .any_hit(any_hit), .win_idx(win_idx),
    .bw_q(bw_q), .sdram_q(sdram_q), .waits_q(waits_q),
    .rd_setup_q(rd_setup_q), .rd_hold_q(rd_hold_q),
    .wr_setup_q(wr_setup_q), .wr_hold_q(wr_hold_q),
    .cs_n(cs_n), .bs_n(bs_n), .ta(ta), .addr_drive(addr_drive),
    .sdram_req(sdram_req), .bus_err(bus_err)
  );

endmodule

// File: tb/test_memcs_unit.sv
`timescale 1ns/1ps
module test_memcs_unit;

  localparam int TO_CYC = 16;
  localparam int OBS    = 40;
  localparam int NV     = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_bw = 2'b10;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_req = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  cs_n;
  logic [3:0]  bs_n;
  logic        ta, addr_drive, sdram_req, bus_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // observation results of one access
  int cs_cnt, cs_first, cs_last, cs_idx, drv_cnt, ta_cnt, ta_at, err_cnt, err_at, sd_cnt, sd_at;
  logic [3:0] bs_seen;

  always #5 clk = ~clk;

  memcs_unit i_memcs_unit (
    .clk(clk), .rst_n(rst_n), .strap_bw(strap_bw), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .cs_n(cs_n), .bs_n(bs_n), .ta(ta),
    .addr_drive(addr_drive), .sdram_req(sdram_req), .bus_err(bus_err)
  );

  // {addr, wr, size, exp region (8 none, 9 sdram), setup, len, hold, bs_n}
  localparam logic [49:0] VEC [NV] = '{
    {32'h1000_0000, 1'b0, 2'b10, 4'd1, 1'b1, 5'd3,  1'b0, 4'b1100},
    {32'h1000_0002, 1'b1, 2'b01, 4'd1, 1'b0, 5'd3,  1'b1, 4'b1100},
    {32'h1000_0003, 1'b0, 2'b00, 4'd1, 1'b1, 5'd3,  1'b0, 4'b1101},
    {32'h1008_0000, 1'b0, 2'b00, 4'd1, 1'b1, 5'd3,  1'b0, 4'b1110},
    {32'h2000_0005, 1'b0, 2'b00, 4'd3, 1'b0, 5'd2,  1'b0, 4'b1101},
    {32'h2000_0006, 1'b0, 2'b01, 4'd3, 1'b0, 5'd2,  1'b0, 4'b0011},
    {32'h2000_0000, 1'b1, 2'b10, 4'd3, 1'b0, 5'd2,  1'b0, 4'b0000},
    {32'h2000_1000, 1'b0, 2'b10, 4'd8, 1'b0, 5'd0,  1'b0, 4'b1111},
    {32'h3FFF_FFFF, 1'b0, 2'b00, 4'd4, 1'b0, 5'd4,  1'b1, 4'b1110},
    {32'h4000_1000, 1'b0, 2'b10, 4'd9, 1'b0, 5'd0,  1'b0, 4'b1111},
    {32'h000F_F000, 1'b0, 2'b10, 4'd0, 1'b0, 5'd1,  1'b0, 4'b0000},
    {32'h0010_0000, 1'b1, 2'b10, 4'd8, 1'b0, 5'd0,  1'b0, 4'b1111},
    {32'h1000_0001, 1'b1, 2'b00, 4'd1, 1'b0, 5'd3,  1'b1, 4'b1101}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    @(negedge clk);
    rst_n = 1'b0; strap_bw = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_acc(input logic [31:0] a, input logic wr, input logic [1:0] sz);
    @(negedge clk);
    acc_req = 1'b1; acc_addr = a; acc_write = wr; acc_size = sz;
    @(negedge clk);
    acc_req = 1'b0;
    cs_cnt = 0; cs_first = -1; cs_last = -1; cs_idx = 15; drv_cnt = 0; ta_cnt = 0; ta_at = -1;
    err_cnt = 0; err_at = -1; sd_cnt = 0; sd_at = -1; bs_seen = 4'hF;
    for (int n = 1; n <= OBS; n++) begin
      if (cs_n != 8'hFF) begin
        if (cs_first < 0) begin
          cs_first = n; bs_seen = bs_n;
          for (int k = 0; k < 8; k++) if (!cs_n[k]) cs_idx = k;
        end
        cs_cnt++; cs_last = n;
      end
      if (addr_drive) drv_cnt++;
      if (ta)        begin ta_cnt++;  ta_at = n;  end
      if (bus_err)   begin err_cnt++; err_at = n; end
      if (sdram_req) begin sd_cnt++;  sd_at = n;  end
      @(negedge clk);
    end
  endtask

  task automatic verify(input int exp_cs, input int setup, input int len, input int hold,
                        input logic [3:0] exp_bs);
    if (exp_cs < 8) begin
      chk(cs_idx == exp_cs, "R3/R4 region select", cs_idx, exp_cs);
      chk(cs_cnt == len, "R5 select length", cs_cnt, len);
      chk(ta_cnt == 1 && ta_at == cs_last, "R5 ta in last select clock", ta_at, cs_last);
      chk(cs_first == 1 + setup, "R6 setup placement", cs_first, 1 + setup);
      chk(drv_cnt == setup + len + hold, "R6 address phase length", drv_cnt, setup + len + hold);
      chk(bs_seen == exp_bs, "R7 byte strobes", bs_seen, exp_bs);
      chk(err_cnt == 0 && sd_cnt == 0, "R3 no error or handoff", err_cnt + sd_cnt, 0);
    end else if (exp_cs == 8) begin
      chk(cs_cnt == 0 && drv_cnt == 0, "R9 no select on miss", cs_cnt, 0);
      chk(err_cnt == 1 && err_at == TO_CYC, "R9 error timing", err_at, TO_CYC);
      chk(ta_cnt == 0, "R9 no ta on miss", ta_cnt, 0);
    end else begin
      chk(sd_cnt == 1 && sd_at == 1, "R8 handoff pulse", sd_at, 1);
      chk(cs_cnt == 0 && ta_cnt == 0 && bs_seen == 4'hF, "R8 no select on handoff", cs_cnt + ta_cnt, 0);
    end
  endtask

  initial begin
    logic [31:0] d;
    do_reset(2'b10);
    @(negedge clk);
    // R1 idle outputs after reset
    chk(cs_n == 8'hFF && bs_n == 4'hF, "R1 idle selects", {cs_n, bs_n}, 12'hFFF);
    chk(!ta && !bus_err && !sdram_req && !addr_drive, "R1 idle flags", {ta, bus_err, sdram_req, addr_drive}, 0);
    rd_reg(4'h0, d); chk(d == 32'h0000_0801, "R1/R2 boot base with strap", d, 32'h0000_0801);
    rd_reg(4'h1, d); chk(d == 32'hFFFF_F0F0, "R1 boot option", d, 32'hFFFF_F0F0);
    rd_reg(4'h2, d); chk(d == 32'h0, "R1 region1 base disabled", d, 0);
    rd_reg(4'hF, d); chk(d == 32'h0, "R1 region7 option cleared", d, 0);
    // R1/R2: boot region answers any address with strap width 16
    run_acc(32'h1234_5678, 1'b0, 2'b10);
    verify(0, 0, 16, 0, 4'b1100);
    // R2: strap change after reset is ignored
    strap_bw = 2'b01;
    rd_reg(4'h0, d); chk(d == 32'h0000_0801, "R2 strap ignored after reset", d, 32'h0000_0801);

    // program regions
    wr_reg(4'h0, 32'h0000_0001); wr_reg(4'h1, 32'h000F_F000);
    wr_reg(4'h2, 32'h1000_0801); wr_reg(4'h3, 32'h000F_F029);
    wr_reg(4'h4, 32'h1008_0401); wr_reg(4'h5, 32'h0000_F006);
    wr_reg(4'h6, 32'h2000_0001); wr_reg(4'h7, 32'h0000_0010);
    wr_reg(4'h8, 32'h3000_0401); wr_reg(4'h9, 32'h0FFF_F034);
    wr_reg(4'hE, 32'h4000_0201); wr_reg(4'hF, 32'h0FFF_F000);
    // R10 reserved bits
    wr_reg(4'hA, 32'hFFFF_FFFF); wr_reg(4'hB, 32'hFFFF_FFFF);
    rd_reg(4'hA, d); chk(d == 32'hFFFF_FC01, "R10 base reserved bits", d, 32'hFFFF_FC01);
    rd_reg(4'hB, d); chk(d == 32'hFFFF_F0FF, "R10 option reserved bits", d, 32'hFFFF_F0FF);
    wr_reg(4'hA, 32'h0); wr_reg(4'hB, 32'h0);
    rd_reg(4'hA, d); chk(d == 32'h0, "R10 region5 cleared", d, 0);
    rd_reg(4'hE, d); chk(d == 32'h4000_0201, "R8 region7 handoff bit kept", d, 32'h4000_0201);
    rd_reg(4'h3, d); chk(d == 32'h000F_F029, "R10 option readback", d, 32'h000F_F029);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      run_acc(v[49:18], v[17], v[16:15]);
      verify(int'(v[14:11]), int'(v[10]), int'(v[9:5]), int'(v[4]), v[3:0]);
    end

    // R2: second reset with 8-bit strap
    do_reset(2'b01);
    rd_reg(4'h0, d); chk(d == 32'h0000_0401, "R2 strap 8-bit", d, 32'h0000_0401);
    rd_reg(4'h2, d); chk(d == 32'h0, "R1 region1 cleared again", d, 0);
    run_acc(32'h0000_0003, 1'b0, 2'b00);
    verify(0, 0, 16, 0, 4'b1110);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule